// File: doc/BRIEF.md
# Prescaled Match Timer

A word-addressed timer/counter for a larger chip. A prescale counter advances on an external count strobe; each time it reaches its programmed limit the next strobe returns it to zero and advances the main counter by one. The main counter therefore moves once every limit+1 strobes while the timer is running and not held.

Four match channels compare their match values against the main counter. A channel fires on the tick that would advance the main counter while the counter equals the channel's match value. A firing channel may flag an interrupt, send the main counter back to zero instead of advancing it, or halt counting, as its three control bits select. It also applies its programmed action to its own match output pin. Software programs and reads everything through a one-cycle register port. Pending flags are cleared by writing ones. The interrupt line is raised while any flag is pending.

Register word addresses: 0 control, 1 main counter, 2 prescale limit, 3 prescale counter, 4 channel control, 5 pending flags, 6 pin register, 8+n match value of channel n. Unused addresses read as zero.

Top module: `pmt_timer`

## Requirements
- R1: While the control register has bit 0 set and bit 1 clear, each strobe increments the prescale counter (address 3). The strobe on which it equals the limit (address 2) clears it and increments the main counter (address 1). Strobes while bit 0 is clear change neither counter.
- R2: Control bit 0 is the run bit and bit 1 is the hold bit, both read back at address 0. While the hold bit is set, both counters are forced to zero on every clock.
- R3: The main counter, prescale counter, limit, channel control register and match values can be written and read back at their addresses. Reset leaves every register at zero.
- R4: Channel n fires on a counter-advancing tick when the main counter equals its match value. If channel control bit 3n is set, pending bit n (address 5) is set.
- R5: When a firing channel has channel control bit 3n+1 set, the main counter loads zero instead of its incremented value.
- R6: When a firing channel has channel control bit 3n+2 set, the main counter keeps its value, the prescale counter reads zero and the run bit clears, so further strobes are ignored.
- R7: Writing pending flags clears each bit written as 1 and leaves each bit written as 0. A flag set by a match in the same cycle stays set.
- R8: The pin register holds the four output levels in bits 0 to 3 and channel n's 2-bit action in bits 4+2n and 5+2n. A write presets levels and actions. On a match, action 0 keeps the pin, 1 drives it low, 2 drives it high and 3 inverts it. The match outputs always show bits 0 to 3.
- R9: The interrupt output is high exactly while at least one pending flag is set.
- R10: Channels firing on the same tick combine. Zeroing and halting both take effect, each flags its own pending bit, and each updates only its own pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe for this cycle |
| bus_addr | input | ADDR_W (4) | Word address for read and write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| count_strobe | input | 1 | One-cycle count strobe from the clock-source block |
| match_out | output | NUM_CH (4) | Match output pin levels |
| irq | output | 1 | Interrupt request, OR of pending flags |

## Verification
The assertions assume that the count strobe and bus signals are synchronous and valid at each clock edge. They also assume that a register write and a hardware update of the same register in one cycle resolve with the write winning, except for the hold bit and the pending flags. The bench drives all inputs shortly after the falling edge and never leaves a write asserted across two edges unintentionally. It keeps match values and the limit inside ranges that the strobe bursts actually reach. A behavioural model in the bench steps on every rising edge and is compared against the match outputs, the interrupt line and the register addressed on each cycle.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

   // channel control bits per channel, in the order the decoder expects
   localparam int unsigned CTL_BITS = 3;
   localparam int unsigned ACT_W    = 2;

   // register word addresses
   localparam int unsigned A_CTRL  = 0;
   localparam int unsigned A_COUNT = 1;
   localparam int unsigned A_LIMIT = 2;
   localparam int unsigned A_PRE   = 3;
   localparam int unsigned A_MCTL  = 4;
   localparam int unsigned A_PEND  = 5;
   localparam int unsigned A_PINS  = 6;
   localparam int unsigned A_MBASE = 8;

   typedef enum logic [ACT_W-1:0] {
      PIN_KEEP = 2'd0,
      PIN_LOW  = 2'd1,
      PIN_HIGH = 2'd2,
      PIN_FLIP = 2'd3
   } pin_act_e;

   // next level of a match pin for a given action
   function automatic logic pin_next(input pin_act_e act, input logic cur);
      logic r;
      case (act)
         PIN_LOW:  r = 1'b0;
         PIN_HIGH: r = 1'b1;
         PIN_FLIP: r = ~cur;
         default:  r = cur;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
   parameter int unsigned W      = 32,
   parameter bit          ENABLE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic         tick,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] limit,
   output logic [W-1:0] value,
   output logic         carry
);

   generate
      if (ENABLE) begin : g_pre
         logic [W-1:0] pc_q;

         assign carry = tick && (pc_q == limit);
         assign value = pc_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pc_q <= '0;
            else if (hold)   pc_q <= '0;
            else if (wr)     pc_q <= wdata;
            else if (carry)  pc_q <= '0;
            else if (tick)   pc_q <= pc_q + 1'b1;
         end
      end else begin : g_direct
         // every strobe advances the main counter
         assign carry = tick;
         assign value = '0;
      end
   endgenerate

endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         carry,
   input  logic         zero_hit,
   input  logic         stop_hit,
   output logic [W-1:0] value
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (hold)      cnt_q <= '0;
      else if (wr)        cnt_q <= wdata;
      else if (carry) begin
         if (zero_hit)      cnt_q <= '0;
         else if (!stop_hit) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign value = cnt_q;

endmodule

// File: rtl/pmt_match_ch.sv
module pmt_match_ch
   import pmt_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mr_wr,
   input  logic [W-1:0]     mr_wdata,
   input  logic [W-1:0]     count,
   input  logic             carry,
   input  logic             pin_wr,
   input  logic             pin_wlevel,
   input  logic [ACT_W-1:0] pin_wact,
   output logic [W-1:0]     mr,
   output logic             hit,
   output logic             pin,
   output logic [ACT_W-1:0] act
);

   logic [W-1:0]     mr_q;
   logic             pin_q;
   pin_act_e         act_q;

   assign hit = carry && (count == mr_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mr_q <= '0;
      else if (mr_wr) mr_q <= mr_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= 1'b0;
         act_q <= PIN_KEEP;
      end else if (pin_wr) begin
         pin_q <= pin_wlevel;
         act_q <= pin_act_e'(pin_wact);
      end else if (hit) begin
         pin_q <= pin_next(act_q, pin_q);
      end
   end

   assign mr  = mr_q;
   assign pin = pin_q;
   assign act = act_q;

endmodule

// File: rtl/pmt_timer.sv
module pmt_timer
   import pmt_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 32,
   parameter bit          PRESCALE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              count_strobe,
   output logic [NUM_CH-1:0] match_out,
   output logic              irq
);

   localparam int unsigned MCTL_W   = CTL_BITS * NUM_CH;
   localparam int unsigned ACT_LSB  = NUM_CH;
   localparam int unsigned PINS_W   = NUM_CH + ACT_W * NUM_CH;
   localparam int unsigned ADDR_TOP = A_MBASE + NUM_CH;

   // elaboration-time parameter checks
   generate
      if (CNT_W > DATA_W) begin : g_err_cnt
         $error("pmt_timer: CNT_W must not exceed DATA_W");
      end
      if (MCTL_W > DATA_W || PINS_W > DATA_W) begin : g_err_fields
         $error("pmt_timer: NUM_CH too large for DATA_W");
      end
      if (ADDR_TOP > (1 << ADDR_W)) begin : g_err_addr
         $error("pmt_timer: ADDR_W too small for NUM_CH match registers");
      end
      if (NUM_CH == 0 || CNT_W < 2) begin : g_err_min
         $error("pmt_timer: NUM_CH and CNT_W out of range");
      end
   endgenerate

   // write decode
   logic wr_ctrl, wr_count, wr_limit, wr_pre, wr_mctl, wr_pend, wr_pins;
   assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
   assign wr_count = bus_wr && (bus_addr == ADDR_W'(A_COUNT));
   assign wr_limit = bus_wr && (bus_addr == ADDR_W'(A_LIMIT));
   assign wr_pre   = bus_wr && (bus_addr == ADDR_W'(A_PRE));
   assign wr_mctl  = bus_wr && (bus_addr == ADDR_W'(A_MCTL));
   assign wr_pend  = bus_wr && (bus_addr == ADDR_W'(A_PEND));
   assign wr_pins  = bus_wr && (bus_addr == ADDR_W'(A_PINS));

   // control and configuration registers
   logic              run_q, hold_q;
   logic [CNT_W-1:0]  limit_q;
   logic [MCTL_W-1:0] mctl_q;
   logic [NUM_CH-1:0] pend_q;

   // datapath nets
   logic              tick, carry;
   logic [CNT_W-1:0]  count_val, pre_val;
   logic [NUM_CH-1:0] hit_vec, ien_vec, zero_vec, stop_vec, pin_vec;
   logic [CNT_W-1:0]  mr_val [NUM_CH];
   logic [ACT_W-1:0]  act_val [NUM_CH];
   logic              zero_hit, stop_hit;

   assign tick     = run_q && !hold_q && count_strobe;
   assign zero_hit = |(hit_vec & zero_vec);
   assign stop_hit = |(hit_vec & stop_vec);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         hold_q <= 1'b0;
      end else if (wr_ctrl) begin
         run_q  <= bus_wdata[0];
         hold_q <= bus_wdata[1];
      end else if (stop_hit) begin
         run_q  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        limit_q <= '0;
      else if (wr_limit) limit_q <= bus_wdata[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mctl_q <= '0;
      else if (wr_mctl) mctl_q <= bus_wdata[MCTL_W-1:0];
   end

   // write-one-to-clear; a new event in the same cycle wins
   logic [NUM_CH-1:0] pend_clr;
   assign pend_clr = wr_pend ? bus_wdata[NUM_CH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~pend_clr) | (hit_vec & ien_vec);
   end

   pmt_prescaler #(
      .W      (CNT_W),
      .ENABLE (PRESCALE_EN)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (hold_q),
      .tick  (tick),
      .wr    (wr_pre),
      .wdata (bus_wdata[CNT_W-1:0]),
      .limit (limit_q),
      .value (pre_val),
      .carry (carry)
   );

   pmt_counter #(
      .W (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (hold_q),
      .wr       (wr_count),
      .wdata    (bus_wdata[CNT_W-1:0]),
      .carry    (carry),
      .zero_hit (zero_hit),
      .stop_hit (stop_hit),
      .value    (count_val)
   );

   logic [PINS_W-1:0] pins_word;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         logic mr_wr;
         assign mr_wr = bus_wr && (bus_addr == ADDR_W'(A_MBASE + i));

         assign ien_vec[i]  = mctl_q[CTL_BITS*i];
         assign zero_vec[i] = mctl_q[CTL_BITS*i + 1];
         assign stop_vec[i] = mctl_q[CTL_BITS*i + 2];

         pmt_match_ch #(
            .W (CNT_W)
         ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .mr_wr      (mr_wr),
            .mr_wdata   (bus_wdata[CNT_W-1:0]),
            .count      (count_val),
            .carry      (carry),
            .pin_wr     (wr_pins),
            .pin_wlevel (bus_wdata[i]),
            .pin_wact   (bus_wdata[ACT_LSB + ACT_W*i +: ACT_W]),
            .mr         (mr_val[i]),
            .hit        (hit_vec[i]),
            .pin        (pin_vec[i]),
            .act        (act_val[i])
         );

         assign pins_word[i]                       = pin_vec[i];
         assign pins_word[ACT_LSB + ACT_W*i +: ACT_W] = act_val[i];
      end
   endgenerate

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(A_CTRL))  bus_rdata = DATA_W'({hold_q, run_q});
      if (bus_addr == ADDR_W'(A_COUNT)) bus_rdata = DATA_W'(count_val);
      if (bus_addr == ADDR_W'(A_LIMIT)) bus_rdata = DATA_W'(limit_q);
      if (bus_addr == ADDR_W'(A_PRE))   bus_rdata = DATA_W'(pre_val);
      if (bus_addr == ADDR_W'(A_MCTL))  bus_rdata = DATA_W'(mctl_q);
      if (bus_addr == ADDR_W'(A_PEND))  bus_rdata = DATA_W'(pend_q);
      if (bus_addr == ADDR_W'(A_PINS))  bus_rdata = DATA_W'(pins_word);
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr == ADDR_W'(A_MBASE + i)) bus_rdata = DATA_W'(mr_val[i]);
      end
   end

   assign match_out = pin_vec;
   assign irq       = |pend_q;

endmodule

// File: rtl/pmt_timer_chk.sv
module pmt_timer_chk #(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned NUM_CH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_q,
   input logic              hold_q,
   input logic              wr_ctrl,
   input logic              wr_count,
   input logic              wr_pend,
   input logic              carry,
   input logic [CNT_W-1:0]  count_val,
   input logic [CNT_W-1:0]  pre_val,
   input logic [NUM_CH-1:0] hit_vec,
   input logic [NUM_CH-1:0] ien_vec,
   input logic [NUM_CH-1:0] zero_vec,
   input logic [NUM_CH-1:0] stop_vec,
   input logic [NUM_CH-1:0] pend_q,
   input logic              irq
);

   // R1: no tick at all while stopped
   a_r1_idle_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> !carry);

   // R1: the main counter only moves on a tick, a write or a hold
   a_r1_count_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_q && !wr_count && !carry) |=> $stable(count_val));

   // R2: hold forces both counters to zero
   a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      hold_q |=> (count_val == '0 && pre_val == '0));

   // R5: a zeroing match sends the counter to zero
   a_r5_zero_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_q && !wr_count && |(hit_vec & zero_vec)) |=> (count_val == '0));

   // R6: a halting match clears the run bit
   a_r6_stop_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ctrl && |(hit_vec & stop_vec)) |=> !run_q);

   // R7: pending flags only leave through a write
   a_r7_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_pend |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

   // R9: the interrupt rises only after an enabled match
   a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|(hit_vec & ien_vec)));

endmodule

bind pmt_timer pmt_timer_chk #(
   .CNT_W  (CNT_W),
   .NUM_CH (NUM_CH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run_q     (run_q),
   .hold_q    (hold_q),
   .wr_ctrl   (wr_ctrl),
   .wr_count  (wr_count),
   .wr_pend   (wr_pend),
   .carry     (carry),
   .count_val (count_val),
   .pre_val   (pre_val),
   .hit_vec   (hit_vec),
   .ien_vec   (ien_vec),
   .zero_vec  (zero_vec),
   .stop_vec  (stop_vec),
   .pend_q    (pend_q),
   .irq       (irq)
);

// File: tb/tb_pmt_timer.sv
module tb_pmt_timer;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 50000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        count_strobe = 1'b0;
   logic [3:0]  match_out;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;
   int rot    = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmt_timer dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_wr       (bus_wr),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .count_strobe (count_strobe),
      .match_out    (match_out),
      .irq          (irq)
   );

   // ---------------- reference model ----------------
   logic        m_run, m_hold;
   logic [31:0] m_tc, m_pc, m_pr;
   logic [11:0] m_mctl;
   logic [3:0]  m_pend, m_lvl;
   logic [1:0]  m_act [4];
   logic [31:0] m_mr  [4];

   function automatic logic [31:0] model_read(input logic [3:0] a);
      case (a)
         4'd0: return {30'b0, m_hold, m_run};
         4'd1: return m_tc;
         4'd2: return m_pr;
         4'd3: return m_pc;
         4'd4: return {20'b0, m_mctl};
         4'd5: return {28'b0, m_pend};
         4'd6: return {20'b0, m_act[3], m_act[2], m_act[1], m_act[0], m_lvl};
         4'd8, 4'd9, 4'd10, 4'd11: return m_mr[a - 4'd8];
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] a);
      case (a)
         4'd0: return "R2";
         4'd1, 4'd3: return "R1";
         4'd5: return "R7";
         4'd6: return "R8";
         default: return "R3";
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run = 0; m_hold = 0; m_tc = 0; m_pc = 0; m_pr = 0;
         m_mctl = 0; m_pend = 0; m_lvl = 0;
         for (int i = 0; i < 4; i++) begin m_act[i] = 0; m_mr[i] = 0; end
      end else begin
         bit tk, cy, zero_any, stop_any;
         bit [3:0] hit;
         logic [31:0] n_tc, n_pc;
         tk = m_run && !m_hold && count_strobe;
         cy = tk && (m_pc == m_pr);
         zero_any = 0; stop_any = 0;
         for (int i = 0; i < 4; i++) begin
            hit[i] = cy && (m_tc == m_mr[i]);
            if (hit[i] && m_mctl[3*i+1]) zero_any = 1;
            if (hit[i] && m_mctl[3*i+2]) stop_any = 1;
         end
         if (m_hold) n_pc = 0;
         else if (bus_wr && bus_addr == 3) n_pc = bus_wdata;
         else if (cy) n_pc = 0;
         else if (tk) n_pc = m_pc + 1;
         else n_pc = m_pc;
         if (m_hold) n_tc = 0;
         else if (bus_wr && bus_addr == 1) n_tc = bus_wdata;
         else if (cy && zero_any) n_tc = 0;
         else if (cy && !stop_any) n_tc = m_tc + 1;
         else n_tc = m_tc;
         for (int i = 0; i < 4; i++) begin
            if (hit[i] && m_mctl[3*i]) m_pend[i] = 1;
            else if (bus_wr && bus_addr == 5 && bus_wdata[i]) m_pend[i] = 0;
         end
         if (bus_wr && bus_addr == 6) begin
            for (int i = 0; i < 4; i++) begin
               m_lvl[i] = bus_wdata[i];
               m_act[i] = bus_wdata[4+2*i +: 2];
            end
         end else begin
            for (int i = 0; i < 4; i++) if (hit[i]) begin
               case (m_act[i])
                  2'd1: m_lvl[i] = 0;
                  2'd2: m_lvl[i] = 1;
                  2'd3: m_lvl[i] = ~m_lvl[i];
                  default: ;
               endcase
            end
         end
         if (bus_wr && bus_addr == 0) begin
            m_run = bus_wdata[0]; m_hold = bus_wdata[1];
         end else if (stop_any) m_run = 0;
         if (bus_wr && bus_addr == 2) m_pr = bus_wdata;
         if (bus_wr && bus_addr == 4) m_mctl = bus_wdata[11:0];
         for (int i = 0; i < 4; i++)
            if (bus_wr && bus_addr == 4'(8+i)) m_mr[i] = bus_wdata;
         m_tc = n_tc; m_pc = n_pc;
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", tag, $time, act, exp);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R8", 32'(match_out), 32'(m_lvl));
         chk("R9", 32'(irq), 32'(|m_pend));
         chk(tag_of(bus_addr), bus_rdata, model_read(bus_addr));
      end
   end

   // ---------------- stimulus ----------------
   task automatic bus_write(input int a, input logic [31:0] d);
      @(negedge clk); #1;
      bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d; count_strobe = 1'b0;
   endtask

   task automatic strobes(input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         bus_wr = 1'b0; count_strobe = 1'b1; bus_addr = 4'(rot % 12); rot++;
         for (int g = 0; g < gap; g++) begin
            @(negedge clk); #1;
            count_strobe = 1'b0; bus_addr = 4'(rot % 12); rot++;
         end
      end
   endtask

   task automatic expect_reg(input string tag, input int a, input logic [31:0] exp);
      @(negedge clk); #1;
      bus_wr = 1'b0; count_strobe = 1'b0; bus_addr = 4'(a);
      @(negedge clk);
      chk(tag, bus_rdata, exp);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            finish_run();
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;

      // reset state
      expect_reg("R3 reset count", 1, 32'd0);
      expect_reg("R2 reset ctrl", 0, 32'd0);
      expect_reg("R8 reset pins", 6, 32'd0);
      expect_reg("R3 reset limit", 2, 32'd0);

      // prescale by 3, continuous strobes
      bus_write(2, 32'd2);
      bus_write(0, 32'd1);
      strobes(9, 0);
      expect_reg("R1 count after 9 strobes", 1, 32'd3);
      expect_reg("R1 prescale after 9 strobes", 3, 32'd0);
      // sparse strobes
      strobes(4, 1);
      expect_reg("R1 count sparse", 1, 32'd4);
      expect_reg("R1 prescale sparse", 3, 32'd1);
      // stopped: strobes ignored
      bus_write(0, 32'd0);
      strobes(5, 0);
      expect_reg("R1 count while stopped", 1, 32'd4);
      // hold
      bus_write(0, 32'd3);
      expect_reg("R2 hold zeroes count", 1, 32'd0);
      expect_reg("R2 hold zeroes prescale", 3, 32'd0);
      expect_reg("R2 ctrl readback", 0, 32'd3);
      strobes(3, 0);
      expect_reg("R2 count held", 1, 32'd0);

      // match with flag and set action on channel 0
      bus_write(0, 32'd0);
      bus_write(2, 32'd0);
      bus_write(8, 32'd5);
      bus_write(4, 32'h001);
      bus_write(6, 32'h020);
      bus_write(0, 32'd1);
      strobes(5, 0);
      expect_reg("R4 no flag before match", 5, 32'd0);
      strobes(1, 0);
      expect_reg("R4 flag after match", 5, 32'd1);
      expect_reg("R8 pin driven high", 6, 32'h021);
      chk("R9 irq with flag", 32'(irq), 32'd1);
      expect_reg("R3 match value readback", 8, 32'd5);
      // write-one-to-clear
      bus_write(5, 32'd0);
      expect_reg("R7 zero write keeps flag", 5, 32'd1);
      bus_write(5, 32'd1);
      expect_reg("R7 one write clears flag", 5, 32'd0);
      chk("R9 irq after clear", 32'(irq), 32'd0);

      // zeroing match on channel 1 with invert action
      bus_write(0, 32'd0);
      bus_write(1, 32'd0);
      bus_write(9, 32'd2);
      bus_write(4, 32'h010);
      bus_write(6, 32'h0C0);
      bus_write(0, 32'd1);
      strobes(3, 0);
      expect_reg("R5 count zeroed on match", 1, 32'd0);
      expect_reg("R8 pin inverted", 6, 32'h0C2);
      strobes(3, 0);
      expect_reg("R8 pin inverted back", 6, 32'h0C0);

      // halting match on channel 2 with prescale by 2
      bus_write(0, 32'd0);
      bus_write(1, 32'd0);
      bus_write(3, 32'd0);
      bus_write(4, 32'h100);
      bus_write(10, 32'd4);
      bus_write(2, 32'd1);
      bus_write(0, 32'd1);
      strobes(10, 0);
      expect_reg("R6 count frozen", 1, 32'd4);
      expect_reg("R6 prescale zero", 3, 32'd0);
      expect_reg("R6 run cleared", 0, 32'd0);
      strobes(4, 0);
      expect_reg("R6 strobes ignored after halt", 1, 32'd4);

      // two channels on the same value: zero + halt, separate pins
      bus_write(8, 32'd3);
      bus_write(11, 32'd3);
      bus_write(4, 32'hA03);
      bus_write(6, 32'h811);
      expect_reg("R8 preset levels and actions", 6, 32'h811);
      bus_write(1, 32'd0);
      bus_write(2, 32'd0);
      bus_write(0, 32'd1);
      strobes(4, 0);
      expect_reg("R10 count zeroed", 1, 32'd0);
      expect_reg("R10 run cleared", 0, 32'd0);
      expect_reg("R10 both flags", 5, 32'h9);
      expect_reg("R10 both pins updated", 6, 32'h818);
      bus_write(5, 32'h8);
      expect_reg("R7 partial clear", 5, 32'h1);
      bus_write(5, 32'h1);
      expect_reg("R7 all clear", 5, 32'h0);

      strobes(6, 1);
      finish_run();
   end

endmodule